// File: doc/BRIEF.md
# SMRAM Window Remap Controller

This block decides whether a host memory access falls into the system-management RAM window and, if it does, which physical address backs it. Software programs an 8-bit control register whose top two bits choose one of four window layouts: a 32 KB window at the top segment, two 64 KB windows that relocate the top segment down onto the low or middle segment, and a 64 KB window that maps the low segment onto itself. One more control bit lets the window be reached while the processor is not in system-management mode.

A second 8-bit register, the shadow control register, interacts with the window. While it holds any nonzero value, the three top-segment layouts are switched off. The low-direct layout is not affected by it. Each cycle the block takes a host address and an SMM-active flag. One cycle later it returns a hit flag and the translated physical address.

Top module: `smw_remap_ctrl`

## Requirements
- R1: After reset, both register readbacks are 0x00, `hit` is 0 and `phys_addr` is 0.
- R2: A write to the control register (`cfg_sel`=0) stores `cfg_wdata & 0xD0`. A write to the shadow register (`cfg_sel`=1) stores all 8 bits. Both are visible on the readback ports from the cycle after the write edge.
- R3: With control bits 7:6 = 00, host addresses 0xE0000 to 0xE7FFF hit and translate to themselves. 0xE8000 and 0xDFFFF miss.
- R4: With bits 7:6 = 01, host addresses 0xE0000 to 0xEFFFF hit and translate to 0xA0000 plus the offset into the window. 0xF0000 misses.
- R5: With bits 7:6 = 10, host addresses 0xE0000 to 0xEFFFF hit and translate to 0xB0000 plus the offset.
- R6: With bits 7:6 = 11, host addresses 0xA0000 to 0xAFFFF hit and translate to themselves. 0xE0000 misses.
- R7: While the shadow register is nonzero, modes 00, 01 and 10 never hit, and mode 11 still hits. Clearing the shadow register restores the top-segment modes.
- R8: An address inside the window hits only if `smm_active` is 1 or control bit 4 (open) is 1.
- R9: `hit` and `phys_addr` are registered and reflect the address presented one cycle earlier. A lookup presented in the same cycle as a register write returns no hit, because every window is torn down while the new setting is applied.
- R10: When `hit` is 0, `phys_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 control, 1 shadow |
| cfg_wdata | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control register contents |
| shadow_rdata | output | 8 | Shadow register contents |
| host_addr | input | ADDR_W (20) | Host address to look up |
| smm_active | input | 1 | Processor is in system-management mode |
| hit | output | 1 | Address lies in an enabled, reachable window |
| phys_addr | output | ADDR_W (20) | Translated physical address, 0 on a miss |

## Verification
The bench builds the block with its default parameters: a 20-bit address, segment bases 0xA0000, 0xB0000 and 0xE0000, and window sizes of 2^15 and 2^16 bytes. These values put every window edge inside the address space, so the bench can probe the first byte, the last byte and the first byte past each window. They also make the relocation offsets distinct between the low and middle targets, so a wrong base selection shows up in `phys_addr`.

// File: rtl/smw_pkg.sv
`timescale 1ns/1ps
package smw_pkg;
    localparam int unsigned REG_W = 8;
    localparam logic [REG_W-1:0] CTRL_WMASK = 8'hD0;
    localparam int unsigned MODE_MSB = 7;
    localparam int unsigned MODE_LSB = 6;
    localparam int unsigned OPEN_BIT = 4;
    localparam int unsigned NUM_MODES = 4;

    typedef enum logic [1:0] {
        MODE_TOP_SMALL  = 2'd0,
        MODE_TOP_TO_LOW = 2'd1,
        MODE_TOP_TO_MID = 2'd2,
        MODE_LOW_DIRECT = 2'd3
    } smw_mode_e;
endpackage

// File: rtl/smw_cfg_regs.sv
`timescale 1ns/1ps
module smw_cfg_regs
    import smw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] shadow
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] shadow;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (sel) begin
                regs_d.shadow = wdata;
            end else begin
                regs_d.ctrl = wdata & CTRL_WMASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl   = regs_q.ctrl;
    assign shadow = regs_q.shadow;
endmodule

// File: rtl/smw_mode_decode.sv
`timescale 1ns/1ps
module smw_mode_decode
    import smw_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned LOW_BASE   = 32'h000A_0000,
    parameter int unsigned MID_BASE   = 32'h000B_0000,
    parameter int unsigned TOP_BASE   = 32'h000E_0000,
    parameter int unsigned SMALL_LOG2 = 15,
    parameter int unsigned LARGE_LOG2 = 16
) (
    input  logic [REG_W-1:0]  ctrl,
    input  logic [REG_W-1:0]  shadow,
    output logic              win_en,
    output logic              win_open,
    output logic [ADDR_W-1:0] host_base,
    output logic [ADDR_W-1:0] phys_base,
    output logic [ADDR_W-1:0] off_mask
);
    logic [ADDR_W-1:0] tbl_host  [NUM_MODES];
    logic [ADDR_W-1:0] tbl_phys  [NUM_MODES];
    logic [ADDR_W-1:0] tbl_mask  [NUM_MODES];
    logic              tbl_gated [NUM_MODES];

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        localparam int unsigned HOST_B = (m == 3) ? LOW_BASE : TOP_BASE;
        localparam int unsigned PHYS_B = (m == 0) ? TOP_BASE :
                                         (m == 1) ? LOW_BASE :
                                         (m == 2) ? MID_BASE : LOW_BASE;
        localparam int unsigned SZ_LOG2 = (m == 0) ? SMALL_LOG2 : LARGE_LOG2;
        localparam longint unsigned MASK_V = (64'd1 << SZ_LOG2) - 64'd1;
        assign tbl_host[m]  = ADDR_W'(HOST_B);
        assign tbl_phys[m]  = ADDR_W'(PHYS_B);
        assign tbl_mask[m]  = ADDR_W'(MASK_V);
        assign tbl_gated[m] = (m != 3);
    end

    smw_mode_e mode;
    logic      shadow_clear;

    always_comb begin
        mode         = smw_mode_e'(ctrl[MODE_MSB:MODE_LSB]);
        shadow_clear = (shadow == '0);
        host_base    = tbl_host[mode];
        phys_base    = tbl_phys[mode];
        off_mask     = tbl_mask[mode];
        win_en       = tbl_gated[mode] ? shadow_clear : 1'b1;
        win_open     = ctrl[OPEN_BIT];
    end
endmodule

// File: rtl/smw_xlate.sv
`timescale 1ns/1ps
module smw_xlate #(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              block,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              smm_active,
    input  logic              win_en,
    input  logic              win_open,
    input  logic [ADDR_W-1:0] host_base,
    input  logic [ADDR_W-1:0] phys_base,
    input  logic [ADDR_W-1:0] off_mask,
    output logic              hit,
    output logic [ADDR_W-1:0] phys_addr
);
    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] phys;
    } out_t;

    out_t out_d, out_q;
    logic              in_win;
    logic              reachable;
    logic              hit_now;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        in_win    = ((host_addr & ~off_mask) == host_base);
        offset    = host_addr - host_base;
        reachable = smm_active | win_open;
        hit_now   = win_en & in_win & reachable & ~block;
        out_d.hit  = hit_now;
        out_d.phys = hit_now ? (phys_base + offset) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hit       = out_q.hit;
    assign phys_addr = out_q.phys;
endmodule

// File: rtl/smw_remap_ctrl.sv
`timescale 1ns/1ps
module smw_remap_ctrl
    import smw_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned LOW_BASE   = 32'h000A_0000,
    parameter int unsigned MID_BASE   = 32'h000B_0000,
    parameter int unsigned TOP_BASE   = 32'h000E_0000,
    parameter int unsigned SMALL_LOG2 = 15,
    parameter int unsigned LARGE_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        ctrl_rdata,
    output logic [7:0]        shadow_rdata,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              smm_active,
    output logic              hit,
    output logic [ADDR_W-1:0] phys_addr
);
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  shadow_q;
    logic              win_en;
    logic              win_open;
    logic [ADDR_W-1:0] host_base;
    logic [ADDR_W-1:0] phys_base;
    logic [ADDR_W-1:0] off_mask;

    smw_cfg_regs i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .ctrl   (ctrl_q),
        .shadow (shadow_q)
    );

    smw_mode_decode #(
        .ADDR_W     (ADDR_W),
        .LOW_BASE   (LOW_BASE),
        .MID_BASE   (MID_BASE),
        .TOP_BASE   (TOP_BASE),
        .SMALL_LOG2 (SMALL_LOG2),
        .LARGE_LOG2 (LARGE_LOG2)
    ) i_decode (
        .ctrl      (ctrl_q),
        .shadow    (shadow_q),
        .win_en    (win_en),
        .win_open  (win_open),
        .host_base (host_base),
        .phys_base (phys_base),
        .off_mask  (off_mask)
    );

    smw_xlate #(
        .ADDR_W (ADDR_W)
    ) i_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .block      (cfg_we),
        .host_addr  (host_addr),
        .smm_active (smm_active),
        .win_en     (win_en),
        .win_open   (win_open),
        .host_base  (host_base),
        .phys_base  (phys_base),
        .off_mask   (off_mask),
        .hit        (hit),
        .phys_addr  (phys_addr)
    );

    assign ctrl_rdata   = ctrl_q;
    assign shadow_rdata = shadow_q;
endmodule

// File: rtl/smw_remap_checker.sv
`timescale 1ns/1ps
module smw_remap_checker #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [7:0]        ctrl_rdata,
    input logic [7:0]        shadow_rdata,
    input logic [ADDR_W-1:0] host_addr,
    input logic              smm_active,
    input logic              hit,
    input logic [ADDR_W-1:0] phys_addr
);
    assert_ctrl_unwritable_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata & 8'h2F) == 8'h00);

    assert_low_direct_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $past(ctrl_rdata[7:6] == 2'b11)) |-> (phys_addr == $past(host_addr)));

    assert_shadow_gates_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $past(shadow_rdata != 8'h00)) |-> $past(ctrl_rdata[7:6] == 2'b11));

    assert_reach_needs_smm_or_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(smm_active || ctrl_rdata[4]));

    assert_write_cycle_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !hit);

    assert_miss_zero_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (phys_addr == '0));
endmodule

bind smw_remap_ctrl smw_remap_checker #(.ADDR_W(ADDR_W)) i_smw_remap_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .ctrl_rdata   (ctrl_rdata),
    .shadow_rdata (shadow_rdata),
    .host_addr    (host_addr),
    .smm_active   (smm_active),
    .hit          (hit),
    .phys_addr    (phys_addr)
);

// File: tb/test_smw_remap_ctrl.sv
`timescale 1ns/1ps
module test_smw_remap_ctrl;
    localparam int unsigned AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [7:0]    cfg_wdata = 8'h00;
    logic [7:0]    ctrl_rdata;
    logic [7:0]    shadow_rdata;
    logic [AW-1:0] host_addr = '0;
    logic          smm_active = 1'b0;
    logic          hit;
    logic [AW-1:0] phys_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    smw_remap_ctrl i_smw_remap_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .ctrl_rdata   (ctrl_rdata),
        .shadow_rdata (shadow_rdata),
        .host_addr    (host_addr),
        .smm_active   (smm_active),
        .hit          (hit),
        .phys_addr    (phys_addr)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [7:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic lookup(string req, logic [AW-1:0] a, logic smm,
                          logic exp_hit, logic [AW-1:0] exp_phys);
        @(negedge clk);
        host_addr  = a;
        smm_active = smm;
        @(posedge clk);
        #1;
        check({req, " hit"}, 32'(hit), 32'(exp_hit));
        check({req, " phys"}, 32'(phys_addr), 32'(exp_phys));
    endtask

    task automatic t_reset();
        check("R1 ctrl", 32'(ctrl_rdata), 32'h00);
        check("R1 shadow", 32'(shadow_rdata), 32'h00);
        check("R1 hit", 32'(hit), 32'h0);
        check("R1 phys", 32'(phys_addr), 32'h0);
    endtask

    task automatic t_mask();
        cfg_write(1'b0, 8'hFF);
        check("R2 ctrl mask ff", 32'(ctrl_rdata), 32'hD0);
        cfg_write(1'b0, 8'h2F);
        check("R2 ctrl mask 2f", 32'(ctrl_rdata), 32'h00);
        cfg_write(1'b1, 8'h5A);
        check("R2 shadow full", 32'(shadow_rdata), 32'h5A);
        cfg_write(1'b1, 8'h00);
        check("R2 shadow clear", 32'(shadow_rdata), 32'h00);
    endtask

    task automatic t_mode0();
        cfg_write(1'b0, 8'h00);
        lookup("R3 first", 20'hE0000, 1'b1, 1'b1, 20'hE0000);
        lookup("R3 last", 20'hE7FFF, 1'b1, 1'b1, 20'hE7FFF);
        lookup("R3 past end R10", 20'hE8000, 1'b1, 1'b0, 20'h0);
        lookup("R3 below", 20'hDFFFF, 1'b1, 1'b0, 20'h0);
    endtask

    task automatic t_mode1();
        cfg_write(1'b0, 8'h40);
        lookup("R4 first", 20'hE0000, 1'b1, 1'b1, 20'hA0000);
        lookup("R4 mid", 20'hE9ABC, 1'b1, 1'b1, 20'hA9ABC);
        lookup("R4 last", 20'hEFFFF, 1'b1, 1'b1, 20'hAFFFF);
        lookup("R4 past end", 20'hF0000, 1'b1, 1'b0, 20'h0);
    endtask

    task automatic t_mode2();
        cfg_write(1'b0, 8'h80);
        lookup("R5 first", 20'hE0000, 1'b1, 1'b1, 20'hB0000);
        lookup("R5 mid", 20'hE1234, 1'b1, 1'b1, 20'hB1234);
        lookup("R5 last", 20'hEFFFF, 1'b1, 1'b1, 20'hBFFFF);
    endtask

    task automatic t_mode3();
        cfg_write(1'b0, 8'hC0);
        lookup("R6 first", 20'hA0000, 1'b1, 1'b1, 20'hA0000);
        lookup("R6 last", 20'hAFFFF, 1'b1, 1'b1, 20'hAFFFF);
        lookup("R6 top miss", 20'hE0000, 1'b1, 1'b0, 20'h0);
        lookup("R6 past end", 20'hB0000, 1'b1, 1'b0, 20'h0);
    endtask

    task automatic t_shadow();
        cfg_write(1'b1, 8'h01);
        check("R7 shadow rd", 32'(shadow_rdata), 32'h01);
        cfg_write(1'b0, 8'h00);
        lookup("R7 mode0 gated", 20'hE0000, 1'b1, 1'b0, 20'h0);
        cfg_write(1'b0, 8'h40);
        lookup("R7 mode1 gated", 20'hE0000, 1'b1, 1'b0, 20'h0);
        cfg_write(1'b0, 8'h80);
        lookup("R7 mode2 gated", 20'hE4000, 1'b1, 1'b0, 20'h0);
        cfg_write(1'b0, 8'hC0);
        lookup("R7 mode3 kept", 20'hA5000, 1'b1, 1'b1, 20'hA5000);
        cfg_write(1'b1, 8'h80);
        lookup("R7 mode3 kept hi", 20'hA0010, 1'b1, 1'b1, 20'hA0010);
        cfg_write(1'b1, 8'h00);
        cfg_write(1'b0, 8'h40);
        lookup("R7 restored", 20'hE0020, 1'b1, 1'b1, 20'hA0020);
    endtask

    task automatic t_open();
        cfg_write(1'b0, 8'h40);
        lookup("R8 closed", 20'hE0000, 1'b0, 1'b0, 20'h0);
        cfg_write(1'b0, 8'h50);
        lookup("R8 open", 20'hE0100, 1'b0, 1'b1, 20'hA0100);
        cfg_write(1'b0, 8'hC0);
        lookup("R8 mode3 closed", 20'hA0000, 1'b0, 1'b0, 20'h0);
    endtask

    task automatic t_write_block();
        cfg_write(1'b0, 8'h50);
        @(negedge clk);
        host_addr  = 20'hE0004;
        smm_active = 1'b1;
        cfg_we     = 1'b1;
        cfg_sel    = 1'b0;
        cfg_wdata  = 8'h50;
        @(posedge clk);
        #1;
        check("R9 write cycle hit", 32'(hit), 32'h0);
        check("R9 write cycle phys", 32'(phys_addr), 32'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk);
        #1;
        check("R9 after write hit", 32'(hit), 32'h1);
        check("R9 after write phys", 32'(phys_addr), 32'hA0004);
        @(negedge clk);
        host_addr = 20'h12345;
        #1;
        check("R9 held until edge", 32'(phys_addr), 32'hA0004);
        @(posedge clk);
        #1;
        check("R9 updated at edge", 32'(hit), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_mask();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_shadow();
        t_open();
        t_write_block();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule